// File: doc/BRIEF.md
# Triple-Path Adder Path Selector

This block steers a floating-point adder built from three parallel datapaths: a bypass path for special operands and operands too far apart to interact, a close path for effective subtraction of operands whose exponents differ by at most one, and a far path for all other cases. For each operation it looks at the two biased exponents, the fraction-is-zero flags, the two signs and the requested add/subtract. It registers a one-hot choice of path together with one enable per path. Those enables gate the operand registers at the head of each datapath, so the two unused paths hold their old operands and do not toggle.

Each operand is also given a class code (zero, denormal, normal, infinity, NaN). This code is registered in the same cycle as the path decision, so the result and flag logic downstream can use it. The adder arithmetic itself lies outside this block. The block only classifies operands and gates the path registers.

Top module: `tpa_path_selector`

## Requirements
- R1: The class codes are zero=0, denormal=1, normal=2, infinity=3 and NaN=4. An exponent of all zeros gives zero when the fraction is zero and denormal otherwise. An exponent of all ones gives infinity when the fraction is zero and NaN otherwise. Any other exponent gives normal.
- R2: The bypass state (state value 3'b001) is chosen when either exponent is all zeros or all ones. This covers zeros, denormals, infinities and NaNs.
- R3: The bypass state is also chosen when the absolute exponent difference exceeds the significand precision, FRAC_W+1. A difference equal to the precision does not select bypass.
- R4: The close state (3'b010) is chosen when bypass does not apply, the effective operation is subtraction, and the exponent difference is 0 or 1.
- R5: The far state (3'b100) is chosen when bypass does not apply and either the effective operation is addition or the exponent difference is 2 or more.
- R6: The effective operation is subtraction exactly when op_sub_i XOR sign_a_i XOR sign_b_i is 1.
- R7: The state and class outputs are registered. They take new values on the first rising clock edge at which valid_i is high. At edges where valid_i is low they keep their values and all three enables are 0.
- R8: After an edge that samples valid_i high, exactly the enable of the chosen path is 1, for one cycle. The enable bits {en_far_o,en_close_o,en_bypass_o} always equal the state at that time. At most one enable is ever 1, and the state is always one-hot.
- R9: While rst_n is low, the state is bypass, all enables are 0 and both class codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | New operation present this cycle |
| op_sub_i | input | 1 | Requested operation, 1 = subtract |
| sign_a_i | input | 1 | Sign of operand A |
| sign_b_i | input | 1 | Sign of operand B |
| exp_a_i | input | EXP_W | Biased exponent of A |
| exp_b_i | input | EXP_W | Biased exponent of B |
| frac_a_zero_i | input | 1 | Fraction of A is all zeros |
| frac_b_zero_i | input | 1 | Fraction of B is all zeros |
| path_state_o | output | 3 | One-hot path: bit0 bypass, bit1 close, bit2 far |
| en_bypass_o | output | 1 | Load enable for bypass-path operand registers |
| en_close_o | output | 1 | Load enable for close-path operand registers |
| en_far_o | output | 1 | Load enable for far-path operand registers |
| class_a_o | output | 3 | Class code of A |
| class_b_o | output | 3 | Class code of B |

## Verification
Every internal fault in this block shows up at the ports one clock edge after the valid operation that exposes it. A wrong exponent difference or limit compare appears as the wrong one-hot state and the wrong enable right after the boundary cases of difference 1, 2, 24 and 25. A wrong sign parity flips close and far only for operations with close exponents. A fault in the hold logic appears on the first idle edge, as a moving state or class, or as an enable that stays high. The directed tests place each of these boundaries in a separate operation, so every such fault is seen in a known cycle.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

   typedef enum logic [2:0] {
      OPC_ZERO   = 3'd0,
      OPC_DENORM = 3'd1,
      OPC_NORMAL = 3'd2,
      OPC_INF    = 3'd3,
      OPC_NAN    = 3'd4
   } opclass_e;

   typedef enum logic [2:0] {
      PATH_BYPASS = 3'b001,
      PATH_CLOSE  = 3'b010,
      PATH_FAR    = 3'b100
   } path_e;

   localparam int NUM_OPS   = 2;
   localparam int NUM_PATHS = 3;

endpackage

// File: rtl/tpa_operand_classifier.sv
module tpa_operand_classifier
   import tpa_pkg::*;
#(
   parameter int EXP_W = 8
) (
   input  logic [EXP_W-1:0] exp_i,
   input  logic             frac_zero_i,
   output opclass_e         class_o,
   output logic             special_o
);

   logic exp_all_zero;
   logic exp_all_one;

   assign exp_all_zero = ~|exp_i;
   assign exp_all_one  = &exp_i;
   assign special_o    = exp_all_zero | exp_all_one;

   always_comb begin
      if (exp_all_zero) begin
         class_o = frac_zero_i ? OPC_ZERO : OPC_DENORM;
      end else if (exp_all_one) begin
         class_o = frac_zero_i ? OPC_INF : OPC_NAN;
      end else begin
         class_o = OPC_NORMAL;
      end
   end

endmodule

// File: rtl/tpa_exp_absdiff.sv
module tpa_exp_absdiff #(
   parameter int EXP_W      = 8,
   parameter int PREC       = 24,
   parameter int DIFF_STYLE = 0
) (
   input  logic [EXP_W-1:0] exp_a_i,
   input  logic [EXP_W-1:0] exp_b_i,
   output logic             beyond_prec_o,
   output logic             near_o
);

   localparam longint MAX_DIFF = (64'd1 << EXP_W) - 64'd1;

   logic [EXP_W-1:0] diff;

   generate
      if (DIFF_STYLE == 0) begin : g_dual_sub
         logic [EXP_W-1:0] d_ab;
         logic [EXP_W-1:0] d_ba;
         logic             a_ge_b;
         assign d_ab   = exp_a_i - exp_b_i;
         assign d_ba   = exp_b_i - exp_a_i;
         assign a_ge_b = exp_a_i >= exp_b_i;
         assign diff   = a_ge_b ? d_ab : d_ba;
      end else begin : g_single_sub
         logic [EXP_W:0] raw;
         assign raw  = {1'b0, exp_a_i} - {1'b0, exp_b_i};
         assign diff = raw[EXP_W] ? (~raw[EXP_W-1:0] + EXP_W'(1)) : raw[EXP_W-1:0];
      end
   endgenerate

   generate
      if (longint'(PREC) >= MAX_DIFF) begin : g_never_beyond
         assign beyond_prec_o = 1'b0;
      end else begin : g_limit_cmp
         localparam logic [EXP_W-1:0] LIMIT = EXP_W'(PREC);
         assign beyond_prec_o = diff > LIMIT;
      end
   endgenerate

   assign near_o = diff <= EXP_W'(1);

endmodule

// File: rtl/tpa_path_decide.sv
module tpa_path_decide
   import tpa_pkg::*;
(
   input  logic  special_i,
   input  logic  beyond_prec_i,
   input  logic  near_i,
   input  logic  op_sub_i,
   input  logic  sign_a_i,
   input  logic  sign_b_i,
   output path_e path_o
);

   logic eff_sub;
   logic take_bypass;

   assign eff_sub     = op_sub_i ^ sign_a_i ^ sign_b_i;
   assign take_bypass = special_i | beyond_prec_i;

   always_comb begin
      if (take_bypass) begin
         path_o = PATH_BYPASS;
      end else if (eff_sub && near_i) begin
         path_o = PATH_CLOSE;
      end else begin
         path_o = PATH_FAR;
      end
   end

endmodule

// File: rtl/tpa_path_selector.sv
module tpa_path_selector
   import tpa_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int FRAC_W     = 23,
   parameter int DIFF_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             op_sub_i,
   input  logic             sign_a_i,
   input  logic             sign_b_i,
   input  logic [EXP_W-1:0] exp_a_i,
   input  logic [EXP_W-1:0] exp_b_i,
   input  logic             frac_a_zero_i,
   input  logic             frac_b_zero_i,
   output logic [2:0]       path_state_o,
   output logic             en_bypass_o,
   output logic             en_close_o,
   output logic             en_far_o,
   output logic [2:0]       class_a_o,
   output logic [2:0]       class_b_o
);

   localparam int PREC = FRAC_W + 1;

   generate
      if (EXP_W < 2 || EXP_W > 30) begin : g_bad_exp_w
         $error("tpa_path_selector: EXP_W must lie in 2..30");
      end
      if (FRAC_W < 1) begin : g_bad_frac_w
         $error("tpa_path_selector: FRAC_W must be at least 1");
      end
      if (DIFF_STYLE != 0 && DIFF_STYLE != 1) begin : g_bad_style
         $error("tpa_path_selector: DIFF_STYLE must be 0 or 1");
      end
   endgenerate

   logic [EXP_W-1:0] exp_arr [NUM_OPS];
   logic [NUM_OPS-1:0] fz_arr;
   logic [NUM_OPS-1:0] special;
   opclass_e           cls [NUM_OPS];

   assign exp_arr[0] = exp_a_i;
   assign exp_arr[1] = exp_b_i;
   assign fz_arr     = {frac_b_zero_i, frac_a_zero_i};

   generate
      for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
         tpa_operand_classifier #(.EXP_W(EXP_W)) u_cls (
            .exp_i       (exp_arr[g]),
            .frac_zero_i (fz_arr[g]),
            .class_o     (cls[g]),
            .special_o   (special[g])
         );
      end
   endgenerate

   logic beyond_prec;
   logic near;

   tpa_exp_absdiff #(
      .EXP_W      (EXP_W),
      .PREC       (PREC),
      .DIFF_STYLE (DIFF_STYLE)
   ) u_diff (
      .exp_a_i       (exp_a_i),
      .exp_b_i       (exp_b_i),
      .beyond_prec_o (beyond_prec),
      .near_o        (near)
   );

   path_e next_path;

   tpa_path_decide u_decide (
      .special_i     (|special),
      .beyond_prec_i (beyond_prec),
      .near_i        (near),
      .op_sub_i      (op_sub_i),
      .sign_a_i      (sign_a_i),
      .sign_b_i      (sign_b_i),
      .path_o        (next_path)
   );

   logic [2:0] state_q;
   logic [2:0] en_q;
   logic [2:0] cls_a_q;
   logic [2:0] cls_b_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PATH_BYPASS;
         en_q    <= '0;
         cls_a_q <= OPC_ZERO;
         cls_b_q <= OPC_ZERO;
      end else if (valid_i) begin
         state_q <= next_path;
         en_q    <= next_path;
         cls_a_q <= cls[0];
         cls_b_q <= cls[1];
      end else begin
         en_q    <= '0;
      end
   end

   assign path_state_o = state_q;
   assign en_bypass_o  = en_q[0];
   assign en_close_o   = en_q[1];
   assign en_far_o     = en_q[2];
   assign class_a_o    = cls_a_q;
   assign class_b_o    = cls_b_q;

   assert_state_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(path_state_o));

   assert_en_onehot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_far_o, en_close_o, en_bypass_o}));

   assert_en_follows_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> ({en_far_o, en_close_o, en_bypass_o} == path_state_o));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(path_state_o) && $stable(class_a_o) && $stable(class_b_o)
                    && !en_bypass_o && !en_close_o && !en_far_o));

   assert_special_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (special != '0)) |=> (path_state_o == PATH_BYPASS));

   assert_nan_class_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (&exp_a_i) && !frac_a_zero_i) |=> (class_a_o == OPC_NAN));

endmodule

// File: tb/tpa_path_selector_tb_top.sv
module tpa_path_selector_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_i = 1'b0;
   logic       op_sub_i = 1'b0;
   logic       sign_a_i = 1'b0;
   logic       sign_b_i = 1'b0;
   logic [7:0] exp_a_i = 8'd0;
   logic [7:0] exp_b_i = 8'd0;
   logic       frac_a_zero_i = 1'b1;
   logic       frac_b_zero_i = 1'b1;
   logic [2:0] path_state_o;
   logic       en_bypass_o, en_close_o, en_far_o;
   logic [2:0] class_a_o, class_b_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   tpa_path_selector dut_i (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_sub_i(op_sub_i),
      .sign_a_i(sign_a_i), .sign_b_i(sign_b_i), .exp_a_i(exp_a_i), .exp_b_i(exp_b_i),
      .frac_a_zero_i(frac_a_zero_i), .frac_b_zero_i(frac_b_zero_i),
      .path_state_o(path_state_o), .en_bypass_o(en_bypass_o), .en_close_o(en_close_o),
      .en_far_o(en_far_o), .class_a_o(class_a_o), .class_b_o(class_b_o));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] model_class(input logic [7:0] e, input logic fz);
      if (e == 8'd0)   return fz ? 3'd0 : 3'd1;
      if (e == 8'hff)  return fz ? 3'd3 : 3'd4;
      return 3'd2;
   endfunction

   function automatic logic [2:0] model_path(input logic s, input logic sa, input logic sb,
                                             input logic [7:0] ea, input logic [7:0] eb);
      int d;
      d = (ea > eb) ? int'(ea) - int'(eb) : int'(eb) - int'(ea);
      if (ea == 0 || eb == 0 || ea == 8'hff || eb == 8'hff || d > 24) return 3'b001;
      if ((s ^ sa ^ sb) && d <= 1) return 3'b010;
      return 3'b100;
   endfunction

   task automatic run_op(input string req, input logic s, input logic sa, input logic sb,
                         input logic [7:0] ea, input logic [7:0] eb,
                         input logic fza, input logic fzb);
      logic [2:0] ep;
      @(negedge clk);
      op_sub_i = s; sign_a_i = sa; sign_b_i = sb; exp_a_i = ea; exp_b_i = eb;
      frac_a_zero_i = fza; frac_b_zero_i = fzb; valid_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      valid_i = 1'b0;
      ep = model_path(s, sa, sb, ea, eb);
      check({req, " path"}, {5'd0, path_state_o}, {5'd0, ep});
      check("R8 enables", {5'd0, en_far_o, en_close_o, en_bypass_o}, {5'd0, ep});
      check("R1 class a", {5'd0, class_a_o}, {5'd0, model_class(ea, fza)});
      check("R1 class b", {5'd0, class_b_o}, {5'd0, model_class(eb, fzb)});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 reset state", {5'd0, path_state_o}, 8'd1);
      check("R9 reset enables", {5'd0, en_far_o, en_close_o, en_bypass_o}, 8'd0);
      check("R9 reset class", {2'd0, class_a_o, class_b_o}, 8'd0);
   endtask

   task automatic t_classes();
      run_op("R1", 0, 0, 0, 8'd0,   8'd0,   1, 0);
      run_op("R1", 0, 0, 0, 8'hff,  8'hff,  1, 0);
      run_op("R1", 0, 0, 0, 8'd100, 8'd1,   0, 1);
      run_op("R1", 0, 0, 0, 8'd254, 8'd200, 1, 0);
   endtask

   task automatic t_bypass_special();
      run_op("R2", 1, 0, 0, 8'd0,   8'd1,   1, 1);
      run_op("R2", 1, 0, 0, 8'd100, 8'hff,  1, 0);
      run_op("R2", 0, 0, 0, 8'hff,  8'd100, 1, 1);
   endtask

   task automatic t_bypass_diff();
      run_op("R3", 0, 0, 0, 8'd130, 8'd105, 1, 1);
      run_op("R3", 0, 0, 0, 8'd105, 8'd130, 1, 1);
      run_op("R3", 1, 0, 0, 8'd130, 8'd106, 1, 1);
      run_op("R3", 0, 0, 0, 8'd2,   8'd254, 1, 1);
   endtask

   task automatic t_close();
      run_op("R4", 1, 0, 0, 8'd100, 8'd100, 1, 1);
      run_op("R4", 1, 0, 0, 8'd100, 8'd101, 0, 1);
      run_op("R4", 1, 0, 0, 8'd101, 8'd100, 1, 0);
      run_op("R4", 1, 0, 0, 8'd1,   8'd2,   1, 1);
   endtask

   task automatic t_far();
      run_op("R5", 1, 0, 0, 8'd102, 8'd100, 1, 1);
      run_op("R5", 1, 0, 0, 8'd100, 8'd102, 1, 1);
      run_op("R5", 0, 0, 0, 8'd100, 8'd100, 1, 1);
      run_op("R5", 0, 0, 0, 8'd100, 8'd101, 1, 1);
   endtask

   task automatic t_effop();
      run_op("R6", 0, 1, 0, 8'd50, 8'd50, 1, 1);
      run_op("R6", 0, 0, 1, 8'd50, 8'd51, 1, 1);
      run_op("R6", 1, 1, 1, 8'd51, 8'd50, 1, 1);
      run_op("R6", 1, 1, 0, 8'd50, 8'd50, 1, 1);
      run_op("R6", 0, 1, 1, 8'd50, 8'd50, 1, 1);
   endtask

   task automatic t_hold();
      run_op("R7", 1, 0, 0, 8'd70, 8'd71, 0, 1);
      @(negedge clk);
      op_sub_i = 0; exp_a_i = 8'd0; exp_b_i = 8'hff; frac_a_zero_i = 0; frac_b_zero_i = 0;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk);
         @(negedge clk);
         check("R7 hold state", {5'd0, path_state_o}, 8'd2);
         check("R7 enables low", {5'd0, en_far_o, en_close_o, en_bypass_o}, 8'd0);
         check("R7 hold class", {2'd0, class_a_o, class_b_o}, {2'd0, 3'd2, 3'd2});
      end
   endtask

   task automatic t_reset_mid();
      run_op("R9", 0, 0, 0, 8'd70, 8'd90, 0, 0);
      @(negedge clk);
      rst_n = 1'b0;
      valid_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R9 reset state", {5'd0, path_state_o}, 8'd1);
      check("R9 reset enables", {5'd0, en_far_o, en_close_o, en_bypass_o}, 8'd0);
      check("R9 reset class", {2'd0, class_a_o, class_b_o}, 8'd0);
      valid_i = 1'b0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_classes();
      t_bypass_special();
      t_bypass_diff();
      t_close();
      t_far();
      t_effop();
      t_hold();
      t_reset_mid();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule